// File: doc/BRIEF.md
# Leveled Priority Interrupt Controller

This block collects up to 63 interrupt request lines and presents to a processor the single most urgent pending request. It reports that request as a 3-bit interrupt level and an 8-bit vector number. Arbitration happens in two tiers. The highest level that has any eligible request is picked first. Then, inside that level, the source with the largest priority is picked. Each level holds nine slots. Eight of them are open to software, and the ninth is a hard-wired source that owns the top priority of its level.

Software programs each source through a small configuration port, one source per write. A write sets the source's mask bit and, on programmable sources, its level and its priority. The same port reads back the addressed source's settings, and the latched pending bits are visible as a vector. Requests are sticky once captured. When the processor strobes acknowledge, the block returns the vector it was presenting in that cycle, keeps that vector until the next strobe, and clears the winner's pending bit.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset no source is pending, every source is masked, every programmable level and priority is 0, the output level is 0, and both the presented vector and the acknowledge vector equal the spurious vector 24.
- R2: A request line that is high at a clock edge sets its pending bit at that edge. The bit stays set after the line drops, until the source is acknowledged.
- R3: A masked pending source, or a programmable source with level 0, stays pending but is never presented.
- R4: The level output, updated at the edge where a request is captured, equals the highest level among the unmasked pending sources with a nonzero level, or 0 when there are none.
- R5: Within the winning level, the largest priority wins. Programmable priorities run 0 to 7. Each fixed source has priority 8, so it beats every programmable source of its level.
- R6: When two eligible sources share both level and priority, the lower source index wins.
- R7: The presented vector is 64 plus the winner's index, or 24 when the level output is 0.
- R8: At an edge with acknowledge high, the acknowledge vector takes the vector presented in that cycle and the winner's pending bit clears. A request arriving in that same cycle cannot change the returned vector, and the acknowledge vector holds until the next acknowledge.
- R9: An acknowledge while the level output is 0 returns 24 and leaves every pending bit unchanged.
- R10: If a source's request line is high in the cycle where that source is acknowledged, its pending bit stays set.
- R11: Sources 56 to 62 are fixed, with level (index - 55). A write to one of them updates only its mask. The read word is {fixed flag, mask, level[2:0], priority[2:0]}, where a fixed source reads back flag 1 and priority 0. The write word is {mask, level[2:0], priority[2:0]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 63 | Request lines, one per source |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 6 | Source selected for write and read |
| cfg_wdata_i | input | 7 | {mask, level, priority} |
| cfg_rdata_o | output | 8 | {fixed, mask, level, priority} of the selected source |
| pend_o | output | 63 | Latched pending bits |
| ack_i | input | 1 | Acknowledge strobe |
| irq_lvl_o | output | 3 | Level of the presented request, 0 when none |
| irq_vec_o | output | 8 | Vector of the presented request |
| ack_vec_o | output | 8 | Vector returned by the last acknowledge |

## Verification
Two functions can land in the same cycle: an acknowledge that latches and clears the current winner, and a new request capture that either changes the winner or re-raises the source being acknowledged. The bench provokes both cases. In one, it drives the acknowledge strobe together with a request at a higher level. In the other, it drives the acknowledge strobe together with the acknowledged source's own line. It then judges the returned vector, the new presented level and vector, and the pending bits one edge later. A table of request pairs exercises the level and priority choice, the tie rule, masking and the fixed slots.

// File: rtl/lic_pkg.sv
package lic_pkg;
    localparam int unsigned LIC_NUM_LVL  = 7;
    localparam int unsigned LIC_SLOTS    = 9;
    localparam int unsigned LIC_VEC_W    = 8;
    localparam int unsigned LIC_VEC_BASE = 64;
    localparam int unsigned LIC_SPUR_VEC = 24;
endpackage

// File: rtl/lic_cfg_regs.sv
module lic_cfg_regs #(
    parameter int unsigned NUM_LVL = lic_pkg::LIC_NUM_LVL,
    parameter int unsigned SLOTS   = lic_pkg::LIC_SLOTS,
    localparam int unsigned NSRC   = NUM_LVL * SLOTS,
    localparam int unsigned NPROG  = NSRC - NUM_LVL,
    localparam int unsigned SEL_W  = $clog2(NSRC),
    localparam int unsigned LVL_W  = $clog2(NUM_LVL + 1),
    localparam int unsigned PPW    = $clog2(SLOTS - 1),
    localparam int unsigned PRIO_W = $clog2(SLOTS),
    localparam int unsigned WD_W   = 1 + LVL_W + PPW
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          we_i,
    input  logic [SEL_W-1:0]              sel_i,
    input  logic [WD_W-1:0]               wdata_i,
    output logic [WD_W:0]                 rdata_o,
    output logic [NSRC-1:0]               mask_d_o,
    output logic [NSRC-1:0][LVL_W-1:0]    lvl_d_o,
    output logic [NSRC-1:0][PRIO_W-1:0]   prio_d_o
);
    localparam logic [SEL_W-1:0] NSRC_S  = SEL_W'(NSRC);
    localparam logic [SEL_W-1:0] NPROG_S = SEL_W'(NPROG);
    localparam logic [PRIO_W-1:0] PRIO_FIXED = PRIO_W'(SLOTS - 1);

    typedef struct packed {
        logic [NSRC-1:0]             mask;
        logic [NPROG-1:0][LVL_W-1:0] lvl;
        logic [NPROG-1:0][PPW-1:0]   prio;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_i && (sel_i < NSRC_S)) begin
            st_d.mask[sel_i] = wdata_i[WD_W-1];
            if (sel_i < NPROG_S) begin
                st_d.lvl[sel_i]  = wdata_i[PPW +: LVL_W];
                st_d.prio[sel_i] = wdata_i[PPW-1:0];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.mask <= '1;
            st_q.lvl  <= '0;
            st_q.prio <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_d_o = st_d.mask;

    for (genvar i = 0; i < NSRC; i++) begin : g_eff
        if (i < NPROG) begin : g_prog
            assign lvl_d_o[i]  = st_d.lvl[i];
            assign prio_d_o[i] = {{(PRIO_W-PPW){1'b0}}, st_d.prio[i]};
        end else begin : g_fixed
            assign lvl_d_o[i]  = LVL_W'(i - NPROG + 1);
            assign prio_d_o[i] = PRIO_FIXED;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (sel_i < NPROG_S) begin
            rdata_o = {1'b0, st_q.mask[sel_i], st_q.lvl[sel_i], st_q.prio[sel_i]};
        end else if (sel_i < NSRC_S) begin
            rdata_o = {1'b1, st_q.mask[sel_i], LVL_W'(sel_i - NPROG_S + SEL_W'(1)), {PPW{1'b0}}};
        end
    end

    // R11: a write to a fixed source leaves every level and priority untouched
    p_fixed_keep_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && (sel_i >= NPROG_S)) |=> ($stable(st_q.lvl) && $stable(st_q.prio)));
endmodule

// File: rtl/lic_pend.sv
module lic_pend #(
    parameter int unsigned NSRC = 63,
    localparam int unsigned SEL_W = $clog2(NSRC)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NSRC-1:0]   irq_i,
    input  logic              clr_i,
    input  logic [SEL_W-1:0]  clr_sel_i,
    output logic [NSRC-1:0]   pend_d_o,
    output logic [NSRC-1:0]   pend_q_o
);
    typedef struct packed {
        logic [NSRC-1:0] bits;
    } pend_state_t;

    pend_state_t st_d, st_q;
    logic [NSRC-1:0] clr_mask;

    always_comb begin
        clr_mask = '0;
        if (clr_i) clr_mask[clr_sel_i] = 1'b1;
        st_d.bits = (st_q.bits & ~clr_mask) | irq_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign pend_d_o = st_d.bits;
    assign pend_q_o = st_q.bits;

    // R2: without a clear, no pending bit drops
    p_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clr_i |=> ((pend_q_o & $past(pend_q_o)) == $past(pend_q_o)));

    // R10: every line high at an edge is pending afterwards, clear or not
    p_capture_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_i != '0) |=> ((pend_q_o & $past(irq_i)) == $past(irq_i)));
endmodule

// File: rtl/lic_arbiter.sv
module lic_arbiter #(
    parameter int unsigned NSRC   = 63,
    parameter int unsigned LVL_W  = 3,
    parameter int unsigned PRIO_W = 4,
    localparam int unsigned SEL_W = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]             pend_i,
    input  logic [NSRC-1:0]             mask_i,
    input  logic [NSRC-1:0][LVL_W-1:0]  lvl_i,
    input  logic [NSRC-1:0][PRIO_W-1:0] prio_i,
    output logic                        win_valid_o,
    output logic [LVL_W-1:0]            win_lvl_o,
    output logic [SEL_W-1:0]            win_sel_o
);
    logic [NSRC-1:0]   elig;
    logic [LVL_W-1:0]  top_lvl;
    logic [PRIO_W-1:0] best_prio;
    logic              found;

    // tier one: highest level carrying an eligible source
    always_comb begin
        top_lvl = '0;
        for (int i = 0; i < NSRC; i++) begin
            elig[i] = pend_i[i] && !mask_i[i] && (lvl_i[i] != '0);
            if (elig[i] && (lvl_i[i] > top_lvl)) top_lvl = lvl_i[i];
        end
    end

    // tier two: largest priority inside that level, strict compare keeps lower index
    always_comb begin
        found     = 1'b0;
        best_prio = '0;
        win_sel_o = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (elig[i] && (lvl_i[i] == top_lvl) && (!found || (prio_i[i] > best_prio))) begin
                found     = 1'b1;
                best_prio = prio_i[i];
                win_sel_o = SEL_W'(i);
            end
        end
    end

    assign win_valid_o = found;
    assign win_lvl_o   = top_lvl;
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl #(
    parameter int unsigned NUM_LVL  = lic_pkg::LIC_NUM_LVL,
    parameter int unsigned SLOTS    = lic_pkg::LIC_SLOTS,
    parameter int unsigned VEC_W    = lic_pkg::LIC_VEC_W,
    parameter int unsigned VEC_BASE = lic_pkg::LIC_VEC_BASE,
    parameter int unsigned SPUR_VEC = lic_pkg::LIC_SPUR_VEC,
    localparam int unsigned NSRC    = NUM_LVL * SLOTS,
    localparam int unsigned SEL_W   = $clog2(NSRC),
    localparam int unsigned LVL_W   = $clog2(NUM_LVL + 1),
    localparam int unsigned PPW     = $clog2(SLOTS - 1),
    localparam int unsigned PRIO_W  = $clog2(SLOTS),
    localparam int unsigned WD_W    = 1 + LVL_W + PPW
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NSRC-1:0]   irq_i,
    input  logic              cfg_we_i,
    input  logic [SEL_W-1:0]  cfg_sel_i,
    input  logic [WD_W-1:0]   cfg_wdata_i,
    output logic [WD_W:0]     cfg_rdata_o,
    output logic [NSRC-1:0]   pend_o,
    input  logic              ack_i,
    output logic [LVL_W-1:0]  irq_lvl_o,
    output logic [VEC_W-1:0]  irq_vec_o,
    output logic [VEC_W-1:0]  ack_vec_o
);
    localparam logic [VEC_W-1:0] SPUR_V = VEC_W'(SPUR_VEC);
    localparam logic [VEC_W-1:0] BASE_V = VEC_W'(VEC_BASE);

    typedef struct packed {
        logic [LVL_W-1:0] lvl;
        logic [VEC_W-1:0] vec;
        logic [SEL_W-1:0] win;
        logic [VEC_W-1:0] ack_vec;
    } top_state_t;

    top_state_t st_d, st_q;

    logic [NSRC-1:0]             mask_d, pend_d, pend_q;
    logic [NSRC-1:0][LVL_W-1:0]  lvl_d;
    logic [NSRC-1:0][PRIO_W-1:0] prio_d;
    logic                        win_valid;
    logic [LVL_W-1:0]            win_lvl;
    logic [SEL_W-1:0]            win_sel;
    logic                        clr_en;

    assign clr_en = ack_i && (st_q.lvl != '0);

    lic_cfg_regs #(.NUM_LVL(NUM_LVL), .SLOTS(SLOTS)) i_cfg (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .we_i     (cfg_we_i),
        .sel_i    (cfg_sel_i),
        .wdata_i  (cfg_wdata_i),
        .rdata_o  (cfg_rdata_o),
        .mask_d_o (mask_d),
        .lvl_d_o  (lvl_d),
        .prio_d_o (prio_d)
    );

    lic_pend #(.NSRC(NSRC)) i_pend (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .irq_i     (irq_i),
        .clr_i     (clr_en),
        .clr_sel_i (st_q.win),
        .pend_d_o  (pend_d),
        .pend_q_o  (pend_q)
    );

    lic_arbiter #(.NSRC(NSRC), .LVL_W(LVL_W), .PRIO_W(PRIO_W)) i_arb (
        .pend_i      (pend_d),
        .mask_i      (mask_d),
        .lvl_i       (lvl_d),
        .prio_i      (prio_d),
        .win_valid_o (win_valid),
        .win_lvl_o   (win_lvl),
        .win_sel_o   (win_sel)
    );

    always_comb begin
        st_d     = st_q;
        st_d.lvl = win_valid ? win_lvl : '0;
        st_d.win = win_sel;
        st_d.vec = win_valid ? (BASE_V + VEC_W'(win_sel)) : SPUR_V;
        if (ack_i) st_d.ack_vec = st_q.vec;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.lvl     <= '0;
            st_q.vec     <= SPUR_V;
            st_q.win     <= '0;
            st_q.ack_vec <= SPUR_V;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o    = pend_q;
    assign irq_lvl_o = st_q.lvl;
    assign irq_vec_o = st_q.vec;
    assign ack_vec_o = st_q.ack_vec;

    // R8: the returned vector is the one presented in the acknowledge cycle
    p_ack_vec_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_i |=> (ack_vec_o == $past(irq_vec_o)));

    // R8: the returned vector holds between strobes
    p_ack_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ack_i |=> $stable(ack_vec_o));

    // R3: a presented winner is pending and unmasked in the pending block
    p_win_eligible_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_lvl_o != '0) |-> (pend_q[st_q.win] && !mask_d[st_q.win]));

    // R8: the acknowledged winner leaves the pending set unless re-raised
    p_ack_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_en && !irq_i[st_q.win]) |=> !pend_q[$past(st_q.win)]);
endmodule

// File: tb/test_lvl_irq_ctrl.sv
`timescale 1ns/1ps
module test_lvl_irq_ctrl;
    localparam int NSRC = 63;
    localparam int NONE = 63;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [62:0] irq = '0;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_sel = '0;
    logic [6:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic [62:0] pend;
    logic        ack = 1'b0;
    logic [2:0]  lvl;
    logic [7:0]  vec;
    logic [7:0]  ack_vec;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    lvl_irq_ctrl i_lvl_irq_ctrl (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .irq_i       (irq),
        .cfg_we_i    (cfg_we),
        .cfg_sel_i   (cfg_sel),
        .cfg_wdata_i (cfg_wdata),
        .cfg_rdata_o (cfg_rdata),
        .pend_o      (pend),
        .ack_i       (ack),
        .irq_lvl_o   (lvl),
        .irq_vec_o   (vec),
        .ack_vec_o   (ack_vec)
    );

    // rows: {src_a, src_b, expected level, expected vector}
    localparam logic [23:0] TBL [12] = '{
        {6'd0,  6'd63, 4'd3, 8'd64},
        {6'd0,  6'd1,  4'd3, 8'd65},
        {6'd1,  6'd3,  4'd3, 8'd65},
        {6'd3,  6'd0,  4'd3, 8'd67},
        {6'd0,  6'd2,  4'd5, 8'd66},
        {6'd4,  6'd63, 4'd1, 8'd68},
        {6'd5,  6'd2,  4'd7, 8'd69},
        {6'd58, 6'd1,  4'd3, 8'd122},
        {6'd59, 6'd0,  4'd4, 8'd123},
        {6'd10, 6'd63, 4'd0, 8'd24},
        {6'd11, 6'd4,  4'd1, 8'd68},
        {6'd10, 6'd4,  4'd1, 8'd68}
    };

    function automatic string row_tag(int r);
        case (r)
            1:       return "R5";
            2:       return "R6";
            3:       return "R6";
            4:       return "R4";
            7:       return "R5";
            8:       return "R11";
            9:       return "R3";
            10:      return "R3";
            11:      return "R3";
            default: return "R7";
        endcase
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cfg_write(int sel, logic [6:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 6'(sel); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse(int a, int b);
        @(negedge clk);
        if (a != NONE) irq[a] = 1'b1;
        if (b != NONE) irq[b] = 1'b1;
        @(negedge clk);
        irq = '0;
    endtask

    task automatic ack_once();
        @(negedge clk);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic drain();
        for (int k = 0; k < 70; k++) begin
            if (lvl == 3'd0) break;
            ack_once();
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(8 * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog actual 0 expected 1");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", int'(lvl), 0);
        check("R1", int'(vec), 24);
        check("R1", int'(ack_vec), 24);
        check("R1", int'(pend != '0), 0);
        cfg_sel = 6'd0;
        #1 check("R1", int'(cfg_rdata), 8'h40);
        cfg_sel = 6'd56;
        #1 check("R1", int'(cfg_rdata), 8'hC8);

        cfg_write(0,  {1'b0, 3'd3, 3'd2});
        cfg_write(1,  {1'b0, 3'd3, 3'd5});
        cfg_write(2,  {1'b0, 3'd5, 3'd0});
        cfg_write(3,  {1'b0, 3'd3, 3'd5});
        cfg_write(4,  {1'b0, 3'd1, 3'd7});
        cfg_write(5,  {1'b0, 3'd7, 3'd0});
        cfg_write(10, {1'b1, 3'd7, 3'd7});
        cfg_write(11, {1'b0, 3'd0, 3'd0});
        cfg_write(58, {1'b0, 3'd7, 3'd7});
        cfg_write(59, {1'b0, 3'd7, 3'd7});

        for (int r = 0; r < 12; r++) begin
            pulse(int'(TBL[r][23:18]), int'(TBL[r][17:12]));
            check(row_tag(r), int'(lvl), int'(TBL[r][11:8]));
            check(row_tag(r), int'(vec), int'(TBL[r][7:0]));
            drain();
        end

        // R3: masked and level-0 sources stay pending
        check("R3", int'(pend[10]), 1);
        check("R3", int'(pend[11]), 1);

        // R2: capture is sticky after the line drops
        pulse(0, 2);
        @(negedge clk);
        check("R2", int'(pend[0] && pend[2]), 1);
        drain();

        // R11: fixed source accepts only its mask
        cfg_write(56, {1'b0, 3'd6, 3'd5});
        cfg_sel = 6'd56;
        #1 check("R11", int'(cfg_rdata), 8'h88);
        pulse(56, 4);
        check("R11", int'(lvl), 1);
        check("R5", int'(vec), 120);
        drain();

        // R8: acknowledge together with a higher new request
        pulse(0, NONE);
        check("R8", int'(vec), 64);
        @(negedge clk);
        ack = 1'b1; irq[2] = 1'b1;
        @(negedge clk);
        ack = 1'b0; irq = '0;
        check("R8", int'(ack_vec), 64);
        check("R8", int'(pend[0]), 0);
        check("R8", int'(lvl), 5);
        check("R8", int'(vec), 66);
        @(negedge clk);
        @(negedge clk);
        check("R8", int'(ack_vec), 64);
        drain();
        check("R8", int'(ack_vec), 66);

        // R10: acknowledge while the same source re-raises
        pulse(1, NONE);
        @(negedge clk);
        ack = 1'b1; irq[1] = 1'b1;
        @(negedge clk);
        ack = 1'b0; irq = '0;
        check("R10", int'(ack_vec), 65);
        check("R10", int'(pend[1]), 1);
        check("R10", int'(vec), 65);
        drain();

        // R9: acknowledge with nothing presented
        check("R9", int'(lvl), 0);
        ack_once();
        check("R9", int'(ack_vec), 24);
        check("R9", int'(pend == ((63'd1 << 10) | (63'd1 << 11))), 1);

        finish_run();
    end
endmodule